// File: doc/BRIEF.md
# Interleaved ADC Sample Frame Multiplexer

This block merges two converter streams into a single byte-wide output stream. One stream carries 8-bit high-frequency (HF) samples. The other carries servo samples from one converter that is shared in turn by four servo signals, called A, B, C and D. Each output frame has eight slots. Servo slots and HF slots alternate, and a frame marker flags the HF slot that comes just before servo A. The output takes one slot per clock. The output byte and the marker change on the falling clock edge, so a receiver that samples on the rising edge sees settled data.

Each input uses a valid/ready handshake. The block raises the ready of exactly one channel in each cycle: the channel whose slot starts at the next rising edge. A servo sample arrives as a signed raw value. The block clamps it to the 6-bit code range and puts the out-of-range flags in the two upper bits of the byte. If a channel has no sample when its slot starts, the block repeats the last byte that channel sent and records a starvation event. A three-bit status word is always visible. It holds sticky HF overflow, HF underflow and starvation flags, and a clear strobe resets them.

Top module: `adc_frame_mux`

## Requirements
- R1: Output slots run in the order servo A, HF, servo B, HF, servo C, HF, servo D, HF, then repeat from servo A. One slot starts at each rising clock edge.
- R2: `frame_sync_o` is 1 only during the HF slot that comes just before a servo A slot. The first slot after reset is that HF slot, so the marker is high on it.
- R3: `frame_data_o` and `frame_sync_o` change only on the falling clock edge. They are unchanged just after each rising edge.
- R4: An HF slot carries the accepted 8-bit HF sample unchanged on bits 7..0.
- R5: `srv_raw_i` is two's complement. A servo slot puts the clamped 6-bit code on bits 5..0. A raw value below 0 gives code 0 with bit 6 set (underflow). A raw value above 63 gives code 63 with bit 7 set (overflow). Any other raw value passes through with bits 7 and 6 clear.
- R6: While reset is inactive, exactly one of `hf_ready_o` and `srv_ready_o` is 1. It names the channel of the slot that starts at the next rising edge. Both are 0 during reset.
- R7: If the channel of a starting slot has valid low, the slot repeats that channel's last byte. For servo, this is the last byte of the same servo signal. The block then sets status bit 2 (starvation), which stays set until cleared.
- R8: An accepted HF sample with `hf_ovf_i` high sets status bit 0, and one with `hf_unf_i` high sets status bit 1. Both bits stay set until cleared.
- R9: `stat_clr_i` clears all three status bits at the rising edge. If an event that sets a bit happens at that same edge, the bit ends up set.
- R10: Synchronous reset sets the output byte, the marker, the status word and every held last value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hf_valid_i | input | 1 | HF sample offered |
| hf_ready_o | output | 1 | HF slot starts at next rising edge |
| hf_data_i | input | 8 | HF sample |
| hf_ovf_i | input | 1 | HF converter overflow for this sample |
| hf_unf_i | input | 1 | HF converter underflow for this sample |
| srv_valid_i | input | 1 | Servo sample offered |
| srv_ready_o | output | 1 | Servo slot starts at next rising edge |
| srv_raw_i | input | 8 | Signed raw servo value |
| stat_clr_i | input | 1 | Clear strobe for the status word |
| status_o | output | 3 | {starvation, HF underflow, HF overflow} |
| frame_data_o | output | 8 | Output slot byte |
| frame_sync_o | output | 1 | Frame marker |

## Verification
The checker checks the following on every rising edge. Exactly one ready is high. The marker is never high for two slots in a row, and a servo slot always follows it. Accepted HF flags and starving slots set their status bits. Set bits stay set until a clear, and a clear with no competing event resets the overflow bit. The bench scenarios cover what those properties cannot show: the slot order over whole frames, the contents of each byte (including clamping at and beyond both ends of the servo range), which value is repeated when a channel starves, and that the output holds across the rising edge and changes only at the falling one.

// File: rtl/fmux_pkg.sv
`timescale 1ns/1ps
package fmux_pkg;
    parameter int HF_W  = 8;
    parameter int SRV_W = 6;
    parameter int RAW_W = 8;
    parameter int N_SRV = 4;

    localparam int N_SLOT  = 2 * N_SRV;
    localparam int SLOT_W  = $clog2(N_SLOT);
    localparam int SIDX_W  = (N_SRV > 1) ? $clog2(N_SRV) : 1;
    localparam int SRV_MAX = (1 << SRV_W) - 1;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [HF_W-1:0]   byte_t;
    typedef logic [SIDX_W-1:0] sidx_t;

    typedef enum logic {
        KIND_SRV = 1'b0,
        KIND_HF  = 1'b1
    } slot_kind_e;

    typedef struct packed {
        logic starve;
        logic hf_unf;
        logic hf_ovf;
    } stat_t;

    typedef struct packed {
        logic             ovf;
        logic             unf;
        logic [SRV_W-1:0] code;
    } srv_word_t;

    localparam slot_t SLOT_PRE_A = slot_t'(N_SLOT - 1);

    function automatic slot_kind_e kind_of(input slot_t s);
        return s[0] ? KIND_HF : KIND_SRV;
    endfunction

    function automatic sidx_t srv_index(input slot_t s);
        return sidx_t'(s >> 1);
    endfunction

    function automatic srv_word_t clamp_servo(input logic signed [RAW_W-1:0] raw);
        srv_word_t w;
        w = '0;
        if (raw < 0) begin
            w.unf  = 1'b1;
            w.code = '0;
        end else if (int'(raw) > SRV_MAX) begin
            w.ovf  = 1'b1;
            w.code = SRV_W'(SRV_MAX);
        end else begin
            w.code = SRV_W'(raw);
        end
        return w;
    endfunction
endpackage

// File: rtl/fmux_slot_seq.sv
`timescale 1ns/1ps
module fmux_slot_seq
    import fmux_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    output slot_kind_e kind_o,
    output sidx_t      sidx_o,
    output logic       pre_a_o,
    output logic       hf_take_o,
    output logic       srv_take_o
);
    slot_t slot_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= SLOT_PRE_A;
        end else if (slot_q == SLOT_PRE_A) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign kind_o     = kind_of(slot_q);
    assign sidx_o     = srv_index(slot_q);
    assign pre_a_o    = (slot_q == SLOT_PRE_A);
    assign hf_take_o  = !rst_i && (kind_o == KIND_HF);
    assign srv_take_o = !rst_i && (kind_o == KIND_SRV);
endmodule

// File: rtl/fmux_hf_lane.sv
`timescale 1ns/1ps
module fmux_hf_lane
    import fmux_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  take_i,
    input  logic  valid_i,
    input  byte_t data_i,
    input  logic  ovf_i,
    input  logic  unf_i,
    output byte_t word_o,
    output logic  ovf_evt_o,
    output logic  unf_evt_o,
    output logic  starve_o
);
    byte_t last_q;
    logic  accept;

    assign accept = take_i && valid_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            last_q <= '0;
        end else if (accept) begin
            last_q <= data_i;
        end
    end

    assign word_o    = valid_i ? data_i : last_q;
    assign ovf_evt_o = accept && ovf_i;
    assign unf_evt_o = accept && unf_i;
    assign starve_o  = take_i && !valid_i;
endmodule

// File: rtl/fmux_srv_lane.sv
`timescale 1ns/1ps
module fmux_srv_lane
    import fmux_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    take_i,
    input  sidx_t                   sidx_i,
    input  logic                    valid_i,
    input  logic signed [RAW_W-1:0] raw_i,
    output byte_t                   word_o,
    output logic                    starve_o
);
    srv_word_t fresh;
    byte_t     held_bus [N_SRV];

    assign fresh = clamp_servo(raw_i);

    for (genvar g = 0; g < N_SRV; g++) begin : g_hold
        byte_t hold_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                hold_q <= '0;
            end else if (take_i && valid_i && (sidx_i == sidx_t'(g))) begin
                hold_q <= byte_t'(fresh);
            end
        end
        assign held_bus[g] = hold_q;
    end

    assign word_o   = valid_i ? byte_t'(fresh) : held_bus[sidx_i];
    assign starve_o = take_i && !valid_i;
endmodule

// File: rtl/fmux_out_stage.sv
`timescale 1ns/1ps
module fmux_out_stage
    import fmux_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  byte_t data_i,
    input  logic  sync_i,
    output byte_t data_o,
    output logic  sync_o
);
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            data_o <= '0;
            sync_o <= 1'b0;
        end else begin
            data_o <= data_i;
            sync_o <= sync_i;
        end
    end
endmodule

// File: rtl/adc_frame_mux.sv
`timescale 1ns/1ps
module adc_frame_mux
    import fmux_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    hf_valid_i,
    output logic                    hf_ready_o,
    input  logic [HF_W-1:0]         hf_data_i,
    input  logic                    hf_ovf_i,
    input  logic                    hf_unf_i,
    input  logic                    srv_valid_i,
    output logic                    srv_ready_o,
    input  logic signed [RAW_W-1:0] srv_raw_i,
    input  logic                    stat_clr_i,
    output logic [2:0]              status_o,
    output logic [HF_W-1:0]         frame_data_o,
    output logic                    frame_sync_o
);
    slot_kind_e kind;
    sidx_t      sidx;
    logic       pre_a;
    byte_t      hf_word, srv_word;
    logic       hf_ovf_evt, hf_unf_evt, hf_starve, srv_starve;
    byte_t      stg_data;
    logic       stg_sync;
    stat_t      stat_q, stat_evt;

    fmux_slot_seq u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .kind_o     (kind),
        .sidx_o     (sidx),
        .pre_a_o    (pre_a),
        .hf_take_o  (hf_ready_o),
        .srv_take_o (srv_ready_o)
    );

    fmux_hf_lane u_hf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .take_i    (hf_ready_o),
        .valid_i   (hf_valid_i),
        .data_i    (hf_data_i),
        .ovf_i     (hf_ovf_i),
        .unf_i     (hf_unf_i),
        .word_o    (hf_word),
        .ovf_evt_o (hf_ovf_evt),
        .unf_evt_o (hf_unf_evt),
        .starve_o  (hf_starve)
    );

    fmux_srv_lane u_srv (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .take_i   (srv_ready_o),
        .sidx_i   (sidx),
        .valid_i  (srv_valid_i),
        .raw_i    (srv_raw_i),
        .word_o   (srv_word),
        .starve_o (srv_starve)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stg_data <= '0;
            stg_sync <= 1'b0;
        end else begin
            stg_data <= (kind == KIND_HF) ? hf_word : srv_word;
            stg_sync <= pre_a;
        end
    end

    always_comb begin
        stat_evt.starve = hf_starve || srv_starve;
        stat_evt.hf_unf = hf_unf_evt;
        stat_evt.hf_ovf = hf_ovf_evt;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
        end else if (stat_clr_i) begin
            stat_q <= stat_evt;
        end else begin
            stat_q <= stat_q | stat_evt;
        end
    end

    assign status_o = stat_q;

    fmux_out_stage u_out (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .data_i (stg_data),
        .sync_i (stg_sync),
        .data_o (frame_data_o),
        .sync_o (frame_sync_o)
    );
endmodule

// File: rtl/adc_frame_mux_chk.sv
`timescale 1ns/1ps
module adc_frame_mux_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       hf_valid_i,
    input logic       hf_ready_o,
    input logic       hf_ovf_i,
    input logic       hf_unf_i,
    input logic       srv_ready_o,
    input logic       stat_clr_i,
    input logic [2:0] status_o,
    input logic       frame_sync_o
);
    AST_ONE_READY: assert property (@(posedge clk_i) disable iff (rst_i) $countones({hf_ready_o, srv_ready_o}) == 1); // R6
    AST_SYNC_BEFORE_A: assert property (@(posedge clk_i) disable iff (rst_i) frame_sync_o |-> srv_ready_o); // R2
    AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i) frame_sync_o |=> !frame_sync_o); // R2
    AST_OVF_SET: assert property (@(posedge clk_i) disable iff (rst_i) (hf_valid_i && hf_ready_o && hf_ovf_i) |=> status_o[0]); // R8
    AST_UNF_SET: assert property (@(posedge clk_i) disable iff (rst_i) (hf_valid_i && hf_ready_o && hf_unf_i) |=> status_o[1]); // R8
    AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (rst_i) (status_o[0] && !stat_clr_i) |=> status_o[0]); // R8
    AST_CLR_OVF: assert property (@(posedge clk_i) disable iff (rst_i) (stat_clr_i && !(hf_valid_i && hf_ready_o && hf_ovf_i)) |=> !status_o[0]); // R9
    AST_STARVE_SET: assert property (@(posedge clk_i) disable iff (rst_i) (hf_ready_o && !hf_valid_i) |=> status_o[2]); // R7
endmodule

bind adc_frame_mux adc_frame_mux_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .hf_valid_i   (hf_valid_i),
    .hf_ready_o   (hf_ready_o),
    .hf_ovf_i     (hf_ovf_i),
    .hf_unf_i     (hf_unf_i),
    .srv_ready_o  (srv_ready_o),
    .stat_clr_i   (stat_clr_i),
    .status_o     (status_o),
    .frame_sync_o (frame_sync_o)
);

// File: tb/tb_adc_frame_mux.sv
`timescale 1ns/1ps
module tb_adc_frame_mux;
    logic              clk = 1'b0;
    logic              rst;
    logic              hf_valid, hf_ready, hf_ovf, hf_unf;
    logic [7:0]        hf_data;
    logic              srv_valid, srv_ready;
    logic signed [7:0] srv_raw;
    logic              stat_clr;
    logic [2:0]        status;
    logic [7:0]        fdata;
    logic              fsync;

    int errors = 0;
    int checks = 0;

    int         m_slot;
    logic [7:0] m_hf_last;
    logic [7:0] m_srv_last [4];
    logic [2:0] m_stat;
    logic [7:0] m_prev_data;
    logic       m_prev_sync;

    always #2.5 clk = ~clk;

    adc_frame_mux dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .hf_valid_i   (hf_valid),
        .hf_ready_o   (hf_ready),
        .hf_data_i    (hf_data),
        .hf_ovf_i     (hf_ovf),
        .hf_unf_i     (hf_unf),
        .srv_valid_i  (srv_valid),
        .srv_ready_o  (srv_ready),
        .srv_raw_i    (srv_raw),
        .stat_clr_i   (stat_clr),
        .status_o     (status),
        .frame_data_o (fdata),
        .frame_sync_o (fsync)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] clamp_ref(input logic signed [7:0] r);
        if (r < 0) return 8'h40;
        if (r > 63) return 8'hBF;
        return {2'b00, r[5:0]};
    endfunction

    // One slot: drive inputs, predict, then check across both clock edges.
    task automatic step(input logic hv, input logic [7:0] hd, input logic ho, input logic hu,
                        input logic sv, input logic signed [7:0] sr, input logic clr,
                        input string tag);
        logic [7:0] exp;
        logic       exp_sync;
        logic [2:0] ev;
        int         idx;
        hf_valid = hv; hf_data = hd; hf_ovf = ho; hf_unf = hu;
        srv_valid = sv; srv_raw = sr; stat_clr = clr;
        #0.1;
        chk(hf_ready, (m_slot % 2) == 1, "R6 hf_ready");
        chk(srv_ready, (m_slot % 2) == 0, "R6 srv_ready");
        ev = 3'b000;
        exp_sync = (m_slot == 7);
        if (m_slot % 2 == 1) begin
            if (hv) begin
                m_hf_last = hd;
                ev[0] = ho;
                ev[1] = hu;
            end else begin
                ev[2] = 1'b1;
            end
            exp = m_hf_last;
        end else begin
            idx = m_slot / 2;
            if (sv) m_srv_last[idx] = clamp_ref(sr);
            else ev[2] = 1'b1;
            exp = m_srv_last[idx];
        end
        m_stat = clr ? ev : (m_stat | ev);
        m_slot = (m_slot + 1) % 8;
        @(posedge clk);
        #1;
        chk(fdata, m_prev_data, "R3 data held past rising edge");
        chk(fsync, m_prev_sync, "R3 sync held past rising edge");
        @(negedge clk);
        #1;
        chk(fdata, exp, tag);
        chk(fsync, exp_sync, "R2 sync");
        chk(status, m_stat, "R8 status");
        m_prev_data = exp;
        m_prev_sync = exp_sync;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        hf_valid = 0; hf_data = 0; hf_ovf = 0; hf_unf = 0;
        srv_valid = 0; srv_raw = 0; stat_clr = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(fdata, 0, "R10 data in reset");
        chk(fsync, 0, "R10 sync in reset");
        chk(status, 0, "R10 status in reset");
        chk({hf_ready, srv_ready}, 0, "R6 readies low in reset");
        m_slot = 7; m_hf_last = 0; m_stat = 0;
        for (int i = 0; i < 4; i++) m_srv_last[i] = 0;
        m_prev_data = 0; m_prev_sync = 0;
        rst = 1'b0;
    endtask

    task automatic t_frame_order();
        for (int i = 0; i < 17; i++)
            step(1, 8'hA0 + 8'(i), 0, 0, 1, 8'(i * 3), 0, "R1 frame order");
    endtask

    task automatic t_servo_clamp();
        logic signed [7:0] raws [8] = '{-8'sd5, 8'sd100, 8'sd63, 8'sd0, -8'sd128, 8'sd127, 8'sd64, 8'sd1};
        for (int i = 0; i < 8; i++) begin
            if (m_slot % 2 == 1) step(1, 8'h11, 0, 0, 1, 0, 0, "R4 hf filler");
            step(1, 8'h22, 0, 0, 1, raws[i], 0, "R5 servo clamp");
        end
    endtask

    task automatic t_hf_full();
        logic [7:0] vals [3] = '{8'hFF, 8'h00, 8'h80};
        for (int i = 0; i < 3; i++) begin
            if (m_slot % 2 == 0) step(1, 0, 0, 0, 1, 8'sd7, 0, "R1 servo filler");
            step(1, vals[i], 0, 0, 1, 8'sd7, 0, "R4 hf byte");
        end
    endtask

    task automatic t_starve();
        step(1, 8'h33, 0, 0, 1, 8'sd9, 1, "R9 clear");
        for (int i = 0; i < 10; i++)
            step(0, 8'h99, 0, 0, 0, 8'sd50, 0, "R7 repeat on starvation");
        step(1, 8'h44, 0, 0, 1, 8'sd2, 0, "R7 resume");
    endtask

    task automatic t_hf_flags();
        if (m_slot % 2 == 0) step(1, 0, 0, 0, 1, 8'sd3, 1, "R9 clear");
        else begin
            step(1, 0, 0, 0, 1, 8'sd3, 1, "R9 clear");
            step(1, 0, 0, 0, 1, 8'sd3, 0, "R1 servo filler");
        end
        // now at an HF slot
        step(1, 8'h55, 1, 0, 1, 8'sd3, 0, "R8 overflow capture");
        step(1, 0, 0, 0, 1, 8'sd3, 0, "R8 hold");
        step(1, 8'h56, 0, 1, 1, 8'sd3, 0, "R8 underflow capture");
        step(1, 0, 0, 0, 1, 8'sd3, 1, "R9 clear flags");
        step(1, 8'h57, 1, 1, 1, 8'sd3, 1, "R9 event beats clear");
        step(1, 0, 0, 0, 1, 8'sd3, 0, "R8 hold after race");
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_frame_order();
        t_servo_clamp();
        t_hf_full();
        t_starve();
        t_hf_flags();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule